// File: doc/BRIEF.md
# Interrupt Active-State Register Bank

This block keeps the "currently being serviced" flag of every interrupt line in an interrupt distributor and exposes it through a byte-wide register bus. Two equal address windows map onto the same state: writing a 1 to a bit of the first window marks that interrupt active, and writing a 1 to a bit of the second marks it inactive. A read from either window returns the current flags for the eight interrupts the byte covers.

The low interrupts (below `NUM_PRIV`) are private to each processor and get one copy per CPU. The requesting CPU index on the bus selects which copy an access sees. The remaining interrupts are shared, so one write changes the state every CPU sees. When security support is on, a non-secure access can neither see nor change interrupts assigned to group 0. The windows exist only on hardware revision 2. On other revisions, writes and clear-window reads are refused with an error flag.

Top module: `irq_active_bank`

## Requirements
- R1: Only byte addresses 0x300..0x3FF are decoded: 0x300..0x37F is the set window and 0x380..0x3FF is the clear window. Byte offset k within a window covers interrupts `BASE_IRQ+8k` to `BASE_IRQ+8k+7`, with data bit b mapped to interrupt `BASE_IRQ+8k+b`. An access outside 0x300..0x3FF returns read data 0 and no error, and changes no state.
- R2: A write to the set window marks active every interrupt whose data bit is 1. The change is visible on `active_out` and to reads from the next cycle.
- R3: A write to the clear window marks inactive every interrupt whose data bit is 1. The change is visible from the next cycle.
- R4: Data bits that are 0 leave the corresponding interrupt unchanged in both windows.
- R5: A read from either window returns, in the same cycle, the active flags of the addressed eight interrupts as seen by the requesting CPU.
- R6: When `REVISION` is not 2, every write to 0x300..0x3FF and every read from 0x380..0x3FF raises `bus_err`. Reads from 0x300..0x37F still return the state without error.
- R7: An access whose first interrupt (`BASE_IRQ+8k`) is at or above `NUM_IRQ` raises `bus_err`.
- R8: Interrupts below `NUM_PRIV` have one flag per CPU. Writes to them change only the copy of the CPU given by `bus_cpu`, and reads return only that copy.
- R9: A write to an interrupt at or above `NUM_PRIV` changes the flag that every CPU sees.
- R10: With `SEC_EXT` set and `bus_secure` low, write bits whose interrupt has `irq_group` bit 0 (group 0) are skipped. The other bits of the same write still take effect.
- R11: With `SEC_EXT` set and `bus_secure` low, read bits of group-0 interrupts return 0.
- R12: `bus_err` is valid in the same cycle as `bus_sel`. An access with `bus_err` high changes no state and returns read data 0.
- R13: Reset (`rst_n` low) clears every private copy and every shared flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data, one bit per interrupt |
| bus_cpu | input | CPU_W | Requesting CPU index |
| bus_secure | input | 1 | 1 = secure access |
| bus_rdata | output | 8 | Read data, one bit per interrupt |
| bus_err | output | 1 | Bad register access |
| irq_group | input | NUM_IRQ | Group per interrupt (0 = group 0) |
| active_out | output | NUM_CPU*NUM_IRQ | Active flags as seen by CPU c at bits c*NUM_IRQ upward |

## Verification
Assertions check three properties on every cycle. A refused access and an all-zero write leave the whole state unchanged. A refused or undecoded access reads as zero. A write to private interrupts never touches another CPU's copy. The bench's scenarios cover the remaining behaviour against a behavioural model: the bit-to-interrupt mapping of both windows, shared propagation to all CPUs, partial application of mixed-group non-secure writes, masked non-secure reads, the range limit, the revision gate (on a second instance built with revision 1), and a reset in the middle of traffic.

// File: rtl/irq_active_pkg.sv
package irq_active_pkg;

    // Byte addresses are 12 bits wide; interrupt indices computed from them fit in 12 bits.
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 12;
    localparam int LANES  = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2
    } act_op_e;

endpackage

// File: rtl/irq_active_decode.sv
module irq_active_decode
    import irq_active_pkg::*;
#(
    parameter int NUM_IRQ  = 64,
    parameter int BASE_IRQ = 0,
    parameter int REVISION = 2,
    parameter bit SEC_EXT  = 1'b1,
    localparam int IRQ_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              secure,
    input  logic [NUM_IRQ-1:0] grp,
    output logic              hit,
    output logic              err,
    output act_op_e           op,
    output logic [IDX_W-1:0]  first_irq,
    output logic [LANES-1:0]  lane_ok
);

    logic             clr_win;
    logic             rev_bad;
    logic             range_bad;
    logic [IDX_W-1:0] irq_n;

    always_comb begin
        hit       = sel && (addr[11:8] == 4'h3);
        clr_win   = addr[7];
        first_irq = IDX_W'({addr[6:0], 3'b000}) + IDX_W'(BASE_IRQ);
        rev_bad   = (REVISION != 2) && (we || clr_win);
        range_bad = first_irq >= IDX_W'(NUM_IRQ);
        err       = hit && (rev_bad || range_bad);

        op = OP_NONE;
        if (hit && we && !err) begin
            op = clr_win ? OP_CLR : OP_SET;
        end

        lane_ok = '0;
        irq_n   = '0;
        for (int b = 0; b < LANES; b++) begin
            irq_n = first_irq + IDX_W'(b);
            if (hit && !err && (irq_n < IDX_W'(NUM_IRQ))) begin
                lane_ok[b] = !(SEC_EXT && !secure && !grp[IRQ_W'(irq_n)]);
            end
        end
    end

endmodule

// File: rtl/irq_active_store.sv
module irq_active_store
    import irq_active_pkg::*;
#(
    parameter int NUM_IRQ  = 64,
    parameter int NUM_CPU  = 2,
    parameter int NUM_PRIV = 32,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IRQ_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int NUM_SHR = NUM_IRQ - NUM_PRIV,
    localparam int PRV_W   = (NUM_PRIV > 1) ? $clog2(NUM_PRIV) : 1,
    localparam int SHR_W   = (NUM_SHR > 1) ? $clog2(NUM_SHR) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  act_op_e                    op,
    input  logic [IDX_W-1:0]           first_irq,
    input  logic [LANES-1:0]           lane_ok,
    input  logic [LANES-1:0]           wdata,
    input  logic [CPU_W-1:0]           cpu,
    output logic [NUM_CPU*NUM_IRQ-1:0] active_out,
    output logic [NUM_IRQ-1:0]         cpu_view
);

    typedef struct packed {
        logic [NUM_CPU-1:0][NUM_PRIV-1:0] priv;
        logic [NUM_SHR-1:0]               shr;
    } act_state_t;

    act_state_t       st_d, st_q;
    logic [IDX_W-1:0] irq_d;
    logic             new_val_d;

    always_comb begin
        st_d      = st_q;
        irq_d     = '0;
        new_val_d = (op == OP_SET);
        for (int b = 0; b < LANES; b++) begin
            irq_d = first_irq + IDX_W'(b);
            if ((op != OP_NONE) && lane_ok[b] && wdata[b]) begin
                if (irq_d < IDX_W'(NUM_PRIV)) begin
                    st_d.priv[cpu][PRV_W'(irq_d)] = new_val_d;
                end else begin
                    st_d.shr[SHR_W'(irq_d - IDX_W'(NUM_PRIV))] = new_val_d;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
            if (i < NUM_PRIV) begin : g_priv
                assign active_out[c*NUM_IRQ+i] = st_q.priv[c][i];
            end else begin : g_shr
                assign active_out[c*NUM_IRQ+i] = st_q.shr[i-NUM_PRIV];
            end
        end

        // R8: a private write by one CPU never disturbs another CPU's copy
        assert_priv_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((op != OP_NONE) && (first_irq < IDX_W'(NUM_PRIV)) && (cpu != CPU_W'(c)))
            |=> $stable(active_out[c*NUM_IRQ +: NUM_PRIV]));
    end

    always_comb begin
        cpu_view = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (cpu == CPU_W'(c)) begin
                cpu_view = active_out[c*NUM_IRQ +: NUM_IRQ];
            end
        end
    end

    // R4: an all-zero write leaves every flag as it was
    assert_zero_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((op != OP_NONE) && (wdata == '0)) |=> $stable(active_out));

endmodule

// File: rtl/irq_active_bank.sv
module irq_active_bank
    import irq_active_pkg::*;
#(
    parameter int NUM_IRQ  = 64,
    parameter int NUM_CPU  = 2,
    parameter int NUM_PRIV = 32,
    parameter int BASE_IRQ = 0,
    parameter int REVISION = 2,
    parameter bit SEC_EXT  = 1'b1,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IRQ_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_we,
    input  logic [11:0]                bus_addr,
    input  logic [7:0]                 bus_wdata,
    input  logic [CPU_W-1:0]           bus_cpu,
    input  logic                       bus_secure,
    output logic [7:0]                 bus_rdata,
    output logic                       bus_err,
    input  logic [NUM_IRQ-1:0]         irq_group,
    output logic [NUM_CPU*NUM_IRQ-1:0] active_out
);

    logic             dec_hit;
    logic             dec_err;
    act_op_e          dec_op;
    logic [IDX_W-1:0] dec_first;
    logic [LANES-1:0] dec_lane_ok;
    logic [NUM_IRQ-1:0] view;
    logic [IDX_W-1:0] rd_irq;

    irq_active_decode #(
        .NUM_IRQ  (NUM_IRQ),
        .BASE_IRQ (BASE_IRQ),
        .REVISION (REVISION),
        .SEC_EXT  (SEC_EXT)
    ) u_decode (
        .sel       (bus_sel),
        .we        (bus_we),
        .addr      (bus_addr),
        .secure    (bus_secure),
        .grp       (irq_group),
        .hit       (dec_hit),
        .err       (dec_err),
        .op        (dec_op),
        .first_irq (dec_first),
        .lane_ok   (dec_lane_ok)
    );

    irq_active_store #(
        .NUM_IRQ  (NUM_IRQ),
        .NUM_CPU  (NUM_CPU),
        .NUM_PRIV (NUM_PRIV)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (dec_op),
        .first_irq  (dec_first),
        .lane_ok    (dec_lane_ok),
        .wdata      (bus_wdata),
        .cpu        (bus_cpu),
        .active_out (active_out),
        .cpu_view   (view)
    );

    always_comb begin
        bus_rdata = '0;
        rd_irq    = '0;
        for (int b = 0; b < LANES; b++) begin
            rd_irq = dec_first + IDX_W'(b);
            if (dec_lane_ok[b] && !bus_we) begin
                bus_rdata[b] = view[IRQ_W'(rd_irq)];
            end
        end
        bus_err = dec_err;
    end

    // R12: a refused access changes nothing
    assert_err_no_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> $stable(active_out));

    // R12: a refused access reads as zero
    assert_err_rdata_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == 8'h00));

    // R1: addresses outside the windows neither flag nor return data nor write
    assert_outside_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && (bus_addr[11:8] != 4'h3)) |-> (!bus_err && (bus_rdata == 8'h00)));

    assert_outside_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_hit) |=> $stable(active_out));

endmodule

// File: tb/irq_active_bank_bench.sv
module irq_active_bank_bench;

    localparam int NIRQ = 64;
    localparam int NCPU = 2;
    localparam int NPRV = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel = 1'b0;
    logic              we = 1'b0;
    logic [11:0]       addr = '0;
    logic [7:0]        wdata = '0;
    logic [0:0]        cpu = '0;
    logic              secure = 1'b1;
    logic [NIRQ-1:0]   grp = 64'h0FFF_FFFF_FFFF_FF0F;
    logic [7:0]        rdata, rdata1;
    logic              err, err1;
    logic [NCPU*NIRQ-1:0] act, act1;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    bit  mdl [NCPU][NIRQ];

    always #10 clk = ~clk;

    irq_active_bank #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .NUM_PRIV(NPRV), .REVISION(2)) u_irq_active_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_cpu(cpu), .bus_secure(secure), .bus_rdata(rdata),
        .bus_err(err), .irq_group(grp), .active_out(act));

    irq_active_bank #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .NUM_PRIV(NPRV), .REVISION(1)) u_rev1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_cpu(cpu), .bus_secure(secure), .bus_rdata(rdata1),
        .bus_err(err1), .irq_group(grp), .active_out(act1));

    task automatic chk(input string req, input logic [127:0] actual, input logic [127:0] expct);
        checks++;
        if (actual !== expct) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, actual, expct);
        end
    endtask

    function automatic logic [127:0] mdl_flat();
        logic [127:0] v = '0;
        for (int c = 0; c < NCPU; c++)
            for (int i = 0; i < NIRQ; i++) v[c*NIRQ+i] = mdl[c][i];
        return v;
    endfunction

    function automatic bit vis(int i, logic s);
        return !(!s && !grp[i]);
    endfunction

    // per-clock comparison of the full state (R2, R3, R8, R9) and of the revision-1 copy (R6)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2/R3/R8/R9 state", act, mdl_flat());
            chk("R6 rev1 state", act1, '0);
        end
    end

    task automatic acc(input logic [11:0] a, input logic w, input logic [7:0] d,
                       input int c, input logic s, input string req);
        bit          hit, clr, bad, bad1;
        int          f;
        logic [7:0]  er;
        @(negedge clk);
        sel = 1'b1; we = w; addr = a; wdata = d; cpu = 1'(c); secure = s;
        hit = (a >= 12'h300) && (a <= 12'h3FF);
        clr = a[7];
        f   = int'(a[6:0]) * 8;
        bad  = hit && (f >= NIRQ);
        bad1 = hit && ((f >= NIRQ) || w || clr);
        er = '0;
        if (hit && !bad && !w)
            for (int b = 0; b < 8; b++)
                if (f + b < NIRQ && vis(f + b, s)) er[b] = mdl[c][f+b];
        #5;
        chk({req, " err"}, 128'(err), 128'(bad));
        chk({req, " rdata"}, 128'(rdata), 128'(er));
        chk({"R6 ", req, " err rev1"}, 128'(err1), 128'(bad1));
        chk({"R6 ", req, " rdata rev1"}, 128'(rdata1), '0);
        @(posedge clk);
        #1;
        if (hit && w && !bad)
            for (int b = 0; b < 8; b++)
                if (d[b] && f + b < NIRQ && vis(f + b, s)) begin
                    if (f + b < NPRV) mdl[c][f+b] = !clr;
                    else for (int k = 0; k < NCPU; k++) mdl[k][f+b] = !clr;
                end
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic clear_model();
        for (int c = 0; c < NCPU; c++)
            for (int i = 0; i < NIRQ; i++) mdl[c][i] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R13 reset state", act, '0);

        // R2 set private on cpu0; R8 cpu1 unaffected
        acc(12'h300, 1, 8'h0F, 0, 1, "R2 set private");
        acc(12'h300, 0, 8'h00, 1, 1, "R8 read other cpu");
        acc(12'h380, 0, 8'h00, 0, 1, "R5 read clear window");
        acc(12'h300, 0, 8'h00, 0, 1, "R5 read set window");
        acc(12'h301, 1, 8'hA5, 1, 1, "R8 set cpu1 private");
        acc(12'h381, 0, 8'h00, 1, 1, "R5 read cpu1");
        acc(12'h301, 0, 8'h00, 0, 1, "R8 read cpu0 byte1");

        // R9 shared
        acc(12'h304, 1, 8'h81, 1, 1, "R9 set shared");
        acc(12'h384, 0, 8'h00, 0, 1, "R9 read shared cpu0");

        // R3 clear and R4 zero write
        acc(12'h380, 1, 8'h05, 0, 1, "R3 clear private");
        acc(12'h384, 1, 8'h01, 0, 1, "R3 clear shared");
        acc(12'h300, 1, 8'h00, 0, 1, "R4 zero set write");
        acc(12'h381, 1, 8'h00, 1, 1, "R4 zero clear write");
        acc(12'h300, 0, 8'h00, 0, 1, "R4 readback");

        // R7 range
        acc(12'h308, 1, 8'hFF, 0, 1, "R7 set beyond range");
        acc(12'h3FF, 0, 8'h00, 0, 1, "R7 read beyond range");
        acc(12'h388, 1, 8'hFF, 1, 1, "R7 clear beyond range");

        // R10 / R11 non-secure filter
        acc(12'h300, 1, 8'hF0, 0, 0, "R10 nonsecure set group0");
        acc(12'h300, 1, 8'hF0, 0, 1, "R10 secure set");
        acc(12'h300, 0, 8'h00, 0, 0, "R11 nonsecure read");
        acc(12'h300, 0, 8'h00, 0, 1, "R11 secure read");
        acc(12'h380, 1, 8'hFF, 0, 0, "R10 nonsecure clear");
        acc(12'h307, 1, 8'hFF, 1, 0, "R10 nonsecure shared mix");
        acc(12'h387, 0, 8'h00, 0, 1, "R10 secure readback");
        acc(12'h307, 0, 8'h00, 0, 0, "R11 nonsecure read shared");

        // R1 outside windows
        acc(12'h2FF, 1, 8'hFF, 0, 1, "R1 below window write");
        acc(12'h400, 1, 8'hFF, 1, 1, "R1 above window write");
        acc(12'h200, 0, 8'h00, 0, 1, "R1 outside read");

        // R6 read of set window on rev1 is legal, writes refused
        acc(12'h302, 1, 8'h3C, 0, 1, "R6 write");
        acc(12'h382, 0, 8'h00, 0, 1, "R6 read clear window");

        // R13 reset during traffic
        @(negedge clk);
        rst_n = 1'b0;
        clear_model();
        @(negedge clk);
        chk("R13 reset mid-run", act, '0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        acc(12'h304, 0, 8'h00, 1, 1, "R13 read after reset");
        acc(12'h305, 1, 8'h42, 0, 1, "R2 set after reset");
        acc(12'h385, 0, 8'h00, 1, 1, "R9 read after reset");

        @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule